// File: doc/BRIEF.md
# Tagged IOMMU Translation Cache

This block is a small, fully associative cache of completed IOMMU address translations. Every entry holds a device-visible page number, a guest soft-context ID, a process soft-context ID, a 2-bit translation-mode tag, a physical page number and a permission field. The mode tag takes part in every compare. As a result, a bypass mapping, a single-stage mapping, a guest-stage-only mapping and a nested mapping for the same page and the same IDs can sit side by side without one answering for another.

A lookup gives the page number, both context IDs, and the mode fields of the first-stage and guest-stage translation pointers. The block derives the request tag from the two mode fields. One cycle later it returns hit, physical page, permission and the derived tag. The page-table walker passes that tag back through the fill port when it installs a new entry after a miss. The invalidate port clears the permission of every entry that matches, all in one cycle. The tag is always compared. The other three keys are compared only where their enable bits are set.

Top module: `xlat_tag_cache`

## Requirements
- R1: After a synchronous reset every entry has permission none (2'b00), rsp_valid is low, and every lookup misses.
- R2: A mode field of zero means bare. The request tag is derived from the two mode fields as follows:
  - both bare gives bypass (0);
  - first stage bare and guest stage not bare gives guest-only (2);
  - first stage not bare and guest stage bare gives single (1);
  - neither bare gives nested (3).

  The derived tag is reported on rsp_tag.
- R3: rsp_valid rises in the cycle after lk_valid. A hit requires all of the following: page number, guest ID, process ID and tag equal to the stored values, and a stored permission that is not none. A hit returns the stored physical page and permission.
- R4: Two entries that differ only in their tag never answer for each other.
- R5: A fill stores page number, both IDs, tag, physical page and permission into the lowest-indexed entry whose permission is none.
- R6: When no entry has permission none, a fill replaces the entry at a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, only on such replacements.
- R7: An invalidate clears to none the permission of every entry whose tag equals inv_tag and which matches each key whose enable bit is set. All other entries keep their contents.
- R8: When an invalidate and a fill occur in the same cycle, the invalidate is applied first. The newly filled entry therefore survives, even when the invalidate would have matched it.
- R9: A lookup is answered from the contents as they stood before any fill or invalidate in the same cycle.
- R10: A miss returns physical page 0 and permission none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_iova | input | IOVA_W | Lookup page number |
| lk_gscid | input | GSCID_W | Lookup guest soft-context ID |
| lk_pscid | input | PSCID_W | Lookup process soft-context ID |
| lk_fs_mode | input | MODE_W | First-stage pointer mode (0 = bare) |
| lk_gs_mode | input | MODE_W | Guest-stage pointer mode (0 = bare) |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_ppn | output | PPN_W | Physical page number on hit |
| rsp_perm | output | 2 | Permission on hit (bit0 read, bit1 write) |
| rsp_tag | output | 2 | Tag derived for the request |
| fill_valid | input | 1 | Install a new entry |
| fill_iova | input | IOVA_W | Page number of the new entry |
| fill_gscid | input | GSCID_W | Guest ID of the new entry |
| fill_pscid | input | PSCID_W | Process ID of the new entry |
| fill_tag | input | 2 | Tag of the new entry |
| fill_ppn | input | PPN_W | Physical page of the new entry |
| fill_perm | input | 2 | Permission of the new entry |
| inv_valid | input | 1 | Invalidate request |
| inv_tag | input | 2 | Tag to match (always compared) |
| inv_gscid_en | input | 1 | Compare guest ID |
| inv_pscid_en | input | 1 | Compare process ID |
| inv_iova_en | input | 1 | Compare page number |
| inv_gscid | input | GSCID_W | Guest ID key |
| inv_pscid | input | PSCID_W | Process ID key |
| inv_iova | input | IOVA_W | Page number key |

## Verification
The bench builds the cache with ENTRIES set to 4 and keeps the default key widths. With only four entries, a few fills are enough to fill the cache, so the step from free-slot placement to round-robin eviction and the wrap of the pointer are reached quickly. The full 44-bit page compares are still exercised. The bench places entries that share every key except the tag next to each other. It also issues invalidates with a wrong tag, with single enables and with no enable at all, and it drives fill, invalidate and lookup in the same cycle to observe the update ordering.

// File: rtl/xlat_cache_pkg.sv
package xlat_cache_pkg;

  typedef enum logic [1:0] {
    TAG_BYPASS = 2'd0,
    TAG_SINGLE = 2'd1,
    TAG_GONLY  = 2'd2,
    TAG_NESTED = 2'd3
  } xlat_tag_e;

  localparam int PERM_W = 2;
  localparam logic [PERM_W-1:0] PERM_NONE = '0;

endpackage

// File: rtl/xlat_mode_tag.sv
module xlat_mode_tag
  import xlat_cache_pkg::*;
#(
  parameter int MODE_W = 4
) (
  input  logic [MODE_W-1:0] fs_mode,
  input  logic [MODE_W-1:0] gs_mode,
  output xlat_tag_e         tag
);

  logic fs_bare;
  logic gs_bare;

  assign fs_bare = (fs_mode == '0);
  assign gs_bare = (gs_mode == '0);

  always_comb begin
    unique case ({fs_bare, gs_bare})
      2'b11:   tag = TAG_BYPASS;
      2'b10:   tag = TAG_GONLY;
      2'b01:   tag = TAG_SINGLE;
      default: tag = TAG_NESTED;
    endcase
  end

endmodule

// File: rtl/xlat_key_match.sv
module xlat_key_match
  import xlat_cache_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IOVA_W  = 44,
  parameter int GSCID_W = 16,
  parameter int PSCID_W = 20
) (
  input  logic [IOVA_W-1:0]  e_iova  [ENTRIES],
  input  logic [GSCID_W-1:0] e_gscid [ENTRIES],
  input  logic [PSCID_W-1:0] e_pscid [ENTRIES],
  input  xlat_tag_e          e_tag   [ENTRIES],
  input  logic [ENTRIES-1:0] e_live,
  input  logic [IOVA_W-1:0]  lk_iova,
  input  logic [GSCID_W-1:0] lk_gscid,
  input  logic [PSCID_W-1:0] lk_pscid,
  input  xlat_tag_e          lk_tag,
  input  logic               inv_valid,
  input  xlat_tag_e          inv_tag,
  input  logic               inv_gscid_en,
  input  logic               inv_pscid_en,
  input  logic               inv_iova_en,
  input  logic [GSCID_W-1:0] inv_gscid,
  input  logic [PSCID_W-1:0] inv_pscid,
  input  logic [IOVA_W-1:0]  inv_iova,
  output logic [ENTRIES-1:0] lk_match,
  output logic [ENTRIES-1:0] inv_match
);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic tag_lk_eq;
    logic tag_inv_eq;
    logic g_ok;
    logic p_ok;
    logic a_ok;

    assign tag_lk_eq  = (e_tag[i] == lk_tag);
    assign tag_inv_eq = (e_tag[i] == inv_tag);

    assign lk_match[i] = e_live[i] && tag_lk_eq &&
                         (e_iova[i]  == lk_iova)  &&
                         (e_gscid[i] == lk_gscid) &&
                         (e_pscid[i] == lk_pscid);

    assign g_ok = !inv_gscid_en || (e_gscid[i] == inv_gscid);
    assign p_ok = !inv_pscid_en || (e_pscid[i] == inv_pscid);
    assign a_ok = !inv_iova_en  || (e_iova[i]  == inv_iova);

    assign inv_match[i] = inv_valid && tag_inv_eq && g_ok && p_ok && a_ok;
  end

endmodule

// File: rtl/xlat_victim_sel.sv
module xlat_victim_sel #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] e_live,
  input  logic               fill_valid,
  output logic [IDX_W-1:0]   victim
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rr_ptr;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!e_live[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign victim = any_free ? free_idx : rr_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_ptr <= '0;
    end else if (fill_valid && !any_free) begin
      rr_ptr <= (rr_ptr == LAST_IDX) ? '0 : rr_ptr + 1'b1;
    end
  end

endmodule

// File: rtl/xlat_tag_cache.sv
module xlat_tag_cache
  import xlat_cache_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IOVA_W  = 44,
  parameter int PPN_W   = 44,
  parameter int GSCID_W = 16,
  parameter int PSCID_W = 20,
  parameter int MODE_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lk_valid,
  input  logic [IOVA_W-1:0]  lk_iova,
  input  logic [GSCID_W-1:0] lk_gscid,
  input  logic [PSCID_W-1:0] lk_pscid,
  input  logic [MODE_W-1:0]  lk_fs_mode,
  input  logic [MODE_W-1:0]  lk_gs_mode,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [PPN_W-1:0]   rsp_ppn,
  output logic [1:0]         rsp_perm,
  output logic [1:0]         rsp_tag,
  input  logic               fill_valid,
  input  logic [IOVA_W-1:0]  fill_iova,
  input  logic [GSCID_W-1:0] fill_gscid,
  input  logic [PSCID_W-1:0] fill_pscid,
  input  logic [1:0]         fill_tag,
  input  logic [PPN_W-1:0]   fill_ppn,
  input  logic [1:0]         fill_perm,
  input  logic               inv_valid,
  input  logic [1:0]         inv_tag,
  input  logic               inv_gscid_en,
  input  logic               inv_pscid_en,
  input  logic               inv_iova_en,
  input  logic [GSCID_W-1:0] inv_gscid,
  input  logic [PSCID_W-1:0] inv_pscid,
  input  logic [IOVA_W-1:0]  inv_iova
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // entry storage
  logic [IOVA_W-1:0]  e_iova  [ENTRIES];
  logic [GSCID_W-1:0] e_gscid [ENTRIES];
  logic [PSCID_W-1:0] e_pscid [ENTRIES];
  xlat_tag_e          e_tag   [ENTRIES];
  logic [PPN_W-1:0]   e_ppn   [ENTRIES];
  logic [PERM_W-1:0]  e_perm  [ENTRIES];
  logic [ENTRIES-1:0] e_live;

  xlat_tag_e          lk_tag;
  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] inv_match;
  logic [IDX_W-1:0]   victim;

  logic               sel_hit;
  logic [PPN_W-1:0]   sel_ppn;
  logic [PERM_W-1:0]  sel_perm;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_live
    assign e_live[i] = (e_perm[i] != PERM_NONE);
  end

  xlat_mode_tag #(
    .MODE_W (MODE_W)
  ) u_mode_tag (
    .fs_mode (lk_fs_mode),
    .gs_mode (lk_gs_mode),
    .tag     (lk_tag)
  );

  xlat_key_match #(
    .ENTRIES (ENTRIES),
    .IOVA_W  (IOVA_W),
    .GSCID_W (GSCID_W),
    .PSCID_W (PSCID_W)
  ) u_match (
    .e_iova       (e_iova),
    .e_gscid      (e_gscid),
    .e_pscid      (e_pscid),
    .e_tag        (e_tag),
    .e_live       (e_live),
    .lk_iova      (lk_iova),
    .lk_gscid     (lk_gscid),
    .lk_pscid     (lk_pscid),
    .lk_tag       (lk_tag),
    .inv_valid    (inv_valid),
    .inv_tag      (xlat_tag_e'(inv_tag)),
    .inv_gscid_en (inv_gscid_en),
    .inv_pscid_en (inv_pscid_en),
    .inv_iova_en  (inv_iova_en),
    .inv_gscid    (inv_gscid),
    .inv_pscid    (inv_pscid),
    .inv_iova     (inv_iova),
    .lk_match     (lk_match),
    .inv_match    (inv_match)
  );

  xlat_victim_sel #(
    .ENTRIES (ENTRIES)
  ) u_victim (
    .clk        (clk),
    .rst        (rst),
    .e_live     (e_live),
    .fill_valid (fill_valid),
    .victim     (victim)
  );

  // lowest matching index wins
  always_comb begin
    sel_hit  = 1'b0;
    sel_ppn  = '0;
    sel_perm = PERM_NONE;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_match[i]) begin
        sel_hit  = 1'b1;
        sel_ppn  = e_ppn[i];
        sel_perm = e_perm[i];
      end
    end
  end

  // permission: invalidate first, fill written after it
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) e_perm[i] <= PERM_NONE;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (inv_match[i]) e_perm[i] <= PERM_NONE;
        if (fill_valid && victim == IDX_W'(i)) e_perm[i] <= fill_perm;
      end
    end
  end

  // key and payload fields carry no reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (fill_valid && victim == IDX_W'(i)) begin
        e_iova[i]  <= fill_iova;
        e_gscid[i] <= fill_gscid;
        e_pscid[i] <= fill_pscid;
        e_tag[i]   <= xlat_tag_e'(fill_tag);
        e_ppn[i]   <= fill_ppn;
      end
    end
  end

  // registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_ppn   <= '0;
      rsp_perm  <= PERM_NONE;
      rsp_tag   <= TAG_BYPASS;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && sel_hit;
      rsp_ppn   <= (lk_valid && sel_hit) ? sel_ppn : '0;
      rsp_perm  <= (lk_valid && sel_hit) ? sel_perm : PERM_NONE;
      rsp_tag   <= lk_tag;
    end
  end

endmodule

// File: rtl/xlat_tag_cache_chk.sv
module xlat_tag_cache_chk
  import xlat_cache_pkg::*;
#(
  parameter int PPN_W  = 44,
  parameter int MODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_valid,
  input logic [MODE_W-1:0] lk_fs_mode,
  input logic [MODE_W-1:0] lk_gs_mode,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [PPN_W-1:0]  rsp_ppn,
  input logic [1:0]        rsp_perm,
  input logic [1:0]        rsp_tag
);

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !rsp_valid);

  p_resp_follows_r3: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);

  p_resp_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);

  p_hit_live_r3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> (rsp_perm != 2'b00));

  p_hit_needs_valid_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid);

  p_miss_blank_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_ppn == '0 && rsp_perm == 2'b00));

  p_bypass_tag_r2: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_fs_mode == '0 && lk_gs_mode == '0) |=> (rsp_tag == 2'(TAG_BYPASS)));

  p_nested_tag_r2: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_fs_mode != '0 && lk_gs_mode != '0) |=> (rsp_tag == 2'(TAG_NESTED)));

endmodule

bind xlat_tag_cache xlat_tag_cache_chk #(
  .PPN_W  (PPN_W),
  .MODE_W (MODE_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .lk_valid   (lk_valid),
  .lk_fs_mode (lk_fs_mode),
  .lk_gs_mode (lk_gs_mode),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_ppn    (rsp_ppn),
  .rsp_perm   (rsp_perm),
  .rsp_tag    (rsp_tag)
);

// File: tb/test_xlat_tag_cache.sv
module test_xlat_tag_cache;

  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 4;
  localparam int IOVA_W = 44, PPN_W = 44, GSCID_W = 16, PSCID_W = 20, MODE_W = 4;

  // tag encodings per R2
  localparam logic [1:0] T_BY = 2'd0, T_SS = 2'd1, T_GO = 2'd2, T_NE = 2'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lk_valid = 1'b0;
  logic [IOVA_W-1:0] lk_iova = '0;
  logic [GSCID_W-1:0] lk_gscid = '0;
  logic [PSCID_W-1:0] lk_pscid = '0;
  logic [MODE_W-1:0] lk_fs_mode = '0, lk_gs_mode = '0;
  logic rsp_valid, rsp_hit;
  logic [PPN_W-1:0] rsp_ppn;
  logic [1:0] rsp_perm, rsp_tag;
  logic fill_valid = 1'b0;
  logic [IOVA_W-1:0] fill_iova = '0;
  logic [GSCID_W-1:0] fill_gscid = '0;
  logic [PSCID_W-1:0] fill_pscid = '0;
  logic [1:0] fill_tag = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic [1:0] fill_perm = '0;
  logic inv_valid = 1'b0;
  logic [1:0] inv_tag = '0;
  logic inv_gscid_en = 1'b0, inv_pscid_en = 1'b0, inv_iova_en = 1'b0;
  logic [GSCID_W-1:0] inv_gscid = '0;
  logic [PSCID_W-1:0] inv_pscid = '0;
  logic [IOVA_W-1:0] inv_iova = '0;

  int n_chk = 0;
  int n_err = 0;

  logic [48:0] exp_q[$];
  string req_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  xlat_tag_cache #(
    .ENTRIES(ENTRIES), .IOVA_W(IOVA_W), .PPN_W(PPN_W),
    .GSCID_W(GSCID_W), .PSCID_W(PSCID_W), .MODE_W(MODE_W)
  ) i_xlat_tag_cache (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_iova(lk_iova), .lk_gscid(lk_gscid), .lk_pscid(lk_pscid),
    .lk_fs_mode(lk_fs_mode), .lk_gs_mode(lk_gs_mode),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn),
    .rsp_perm(rsp_perm), .rsp_tag(rsp_tag),
    .fill_valid(fill_valid), .fill_iova(fill_iova), .fill_gscid(fill_gscid),
    .fill_pscid(fill_pscid), .fill_tag(fill_tag), .fill_ppn(fill_ppn), .fill_perm(fill_perm),
    .inv_valid(inv_valid), .inv_tag(inv_tag), .inv_gscid_en(inv_gscid_en),
    .inv_pscid_en(inv_pscid_en), .inv_iova_en(inv_iova_en),
    .inv_gscid(inv_gscid), .inv_pscid(inv_pscid), .inv_iova(inv_iova)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  // driver: lookup with explicit modes
  task automatic lk_modes(input logic [43:0] a, input logic [15:0] g, input logic [19:0] p,
                          input logic [3:0] fs, input logic [3:0] gs,
                          input logic ehit, input logic [43:0] eppn, input logic [1:0] eperm,
                          input logic [1:0] etag, input string req);
    lk_valid = 1'b1; lk_iova = a; lk_gscid = g; lk_pscid = p;
    lk_fs_mode = fs; lk_gs_mode = gs;
    exp_q.push_back({ehit, ehit ? eppn : 44'd0, ehit ? eperm : 2'd0, etag});
    req_q.push_back(req);
  endtask

  // driver: lookup choosing modes that give tag t per R2
  task automatic lk(input logic [43:0] a, input logic [15:0] g, input logic [19:0] p,
                    input logic [1:0] t, input logic ehit, input logic [43:0] eppn,
                    input logic [1:0] eperm, input string req);
    logic [3:0] fs, gs;
    fs = (t == T_SS || t == T_NE) ? 4'd8 : 4'd0;
    gs = (t == T_GO || t == T_NE) ? 4'd8 : 4'd0;
    lk_modes(a, g, p, fs, gs, ehit, eppn, eperm, t, req);
  endtask

  task automatic fill(input logic [43:0] a, input logic [15:0] g, input logic [19:0] p,
                      input logic [1:0] t, input logic [43:0] ppn, input logic [1:0] perm);
    fill_valid = 1'b1; fill_iova = a; fill_gscid = g; fill_pscid = p;
    fill_tag = t; fill_ppn = ppn; fill_perm = perm;
  endtask

  task automatic inv(input logic [1:0] t, input logic ge, input logic pe, input logic ae,
                     input logic [15:0] g, input logic [19:0] p, input logic [43:0] a);
    inv_valid = 1'b1; inv_tag = t; inv_gscid_en = ge; inv_pscid_en = pe; inv_iova_en = ae;
    inv_gscid = g; inv_pscid = p; inv_iova = a;
  endtask

  task automatic step();
    @(negedge clk);
    lk_valid = 1'b0; fill_valid = 1'b0; inv_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_err++;
        $display("FAIL R3: response with nothing pending actual=%b expected=no response", rsp_valid);
      end else begin
        logic [48:0] e;
        logic [48:0] act;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        act = {rsp_hit, rsp_ppn, rsp_perm, rsp_tag};
        if (act !== e) begin
          n_err++;
          $display("FAIL %s: actual hit=%b ppn=%h perm=%b tag=%0d expected hit=%b ppn=%h perm=%b tag=%0d",
                   r, act[48], act[47:4], act[3:2], act[1:0], e[48], e[47:4], e[3:2], e[1:0]);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=run completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    n_chk++;
    if (rsp_valid !== 1'b0) begin
      n_err++;
      $display("FAIL R1: rsp_valid after reset actual=%b expected=0", rsp_valid);
    end

    // R1 R10: empty cache misses; R2 tag derivation with varied non-zero modes
    lk_modes(44'h10, 16'd1, 20'd1, 4'd0, 4'd0, 1'b0, 0, 0, T_BY, "R1 miss after reset"); step();
    lk_modes(44'h10, 16'd1, 20'd1, 4'd0, 4'd9, 1'b0, 0, 0, T_GO, "R2 bare/non-bare gives guest-only"); step();
    lk_modes(44'h10, 16'd1, 20'd1, 4'd3, 4'd0, 1'b0, 0, 0, T_SS, "R2 non-bare/bare gives single"); step();
    lk_modes(44'h10, 16'd1, 20'd1, 4'd15, 4'd1, 1'b0, 0, 0, T_NE, "R10 R2 nested miss"); step();

    // R5 R3: fill then hit; key mismatches miss
    fill(44'h100, 16'd1, 20'd2, T_SS, 44'hAAA, 2'd3); step();
    lk(44'h100, 16'd1, 20'd2, T_SS, 1'b1, 44'hAAA, 2'd3, "R3 R5 single hit"); step();
    lk(44'h100, 16'd1, 20'd2, T_NE, 1'b0, 0, 0, "R4 nested must not alias single"); step();
    lk(44'h100, 16'd1, 20'd3, T_SS, 1'b0, 0, 0, "R3 pscid mismatch"); step();
    lk(44'h100, 16'd2, 20'd2, T_SS, 1'b0, 0, 0, "R3 gscid mismatch"); step();
    lk(44'h101, 16'd1, 20'd2, T_SS, 1'b0, 0, 0, "R3 iova mismatch"); step();

    // R4: same keys, nested tag, separate entry
    fill(44'h100, 16'd1, 20'd2, T_NE, 44'hBBB, 2'd1); step();
    lk(44'h100, 16'd1, 20'd2, T_NE, 1'b1, 44'hBBB, 2'd1, "R4 nested hit"); step();
    lk(44'h100, 16'd1, 20'd2, T_SS, 1'b1, 44'hAAA, 2'd3, "R4 single unchanged"); step();

    fill(44'h200, 16'd1, 20'd5, T_GO, 44'hCCC, 2'd2); step();
    fill(44'h300, 16'd2, 20'd5, T_GO, 44'hDDD, 2'd3); step();

    // R7: gscid-enabled invalidate
    inv(T_GO, 1'b1, 1'b0, 1'b0, 16'd1, 20'd0, 44'h0); step();
    lk(44'h200, 16'd1, 20'd5, T_GO, 1'b0, 0, 0, "R7 gscid invalidate cleared entry"); step();
    lk(44'h300, 16'd2, 20'd5, T_GO, 1'b1, 44'hDDD, 2'd3, "R7 other gscid kept"); step();

    // R5: free slot (index 2) reused; then R6 round robin from 0
    fill(44'h400, 16'd3, 20'd0, T_BY, 44'hEEE, 2'd3); step();
    lk(44'h100, 16'd1, 20'd2, T_SS, 1'b1, 44'hAAA, 2'd3, "R5 free slot used, slot0 kept"); step();
    fill(44'h500, 16'd3, 20'd0, T_BY, 44'h555, 2'd3); step();
    lk(44'h100, 16'd1, 20'd2, T_SS, 1'b0, 0, 0, "R6 pointer 0 evicted"); step();
    lk(44'h100, 16'd1, 20'd2, T_NE, 1'b1, 44'hBBB, 2'd1, "R6 slot1 kept"); step();
    fill(44'h600, 16'd3, 20'd0, T_BY, 44'h666, 2'd3); step();
    lk(44'h100, 16'd1, 20'd2, T_NE, 1'b0, 0, 0, "R6 pointer 1 evicted"); step();
    lk(44'h300, 16'd2, 20'd5, T_GO, 1'b1, 44'hDDD, 2'd3, "R6 slot3 kept"); step();
    lk(44'h400, 16'd3, 20'd0, T_BY, 1'b1, 44'hEEE, 2'd3, "R6 slot2 kept"); step();

    // R7: wrong tag has no effect; tag-only invalidate
    inv(T_SS, 1'b0, 1'b0, 1'b1, 16'd0, 20'd0, 44'h300); step();
    lk(44'h300, 16'd2, 20'd5, T_GO, 1'b1, 44'hDDD, 2'd3, "R7 wrong tag ignored"); step();
    inv(T_GO, 1'b0, 1'b0, 1'b0, 16'd0, 20'd0, 44'h0); step();
    lk(44'h300, 16'd2, 20'd5, T_GO, 1'b0, 0, 0, "R7 tag-wide invalidate"); step();
    lk(44'h400, 16'd3, 20'd0, T_BY, 1'b1, 44'hEEE, 2'd3, "R7 other tag kept"); step();
    inv(T_BY, 1'b0, 1'b1, 1'b0, 16'd0, 20'd7, 44'h0); step();
    lk(44'h400, 16'd3, 20'd0, T_BY, 1'b1, 44'hEEE, 2'd3, "R7 pscid key no match"); step();
    inv(T_BY, 1'b0, 1'b0, 1'b1, 16'd0, 20'd0, 44'h500); step();
    lk(44'h500, 16'd3, 20'd0, T_BY, 1'b0, 0, 0, "R7 iova invalidate"); step();
    lk(44'h600, 16'd3, 20'd0, T_BY, 1'b1, 44'h666, 2'd3, "R7 iova neighbour kept"); step();

    // R8: invalidate and fill together, fill survives
    inv(T_BY, 1'b0, 1'b0, 1'b0, 16'd0, 20'd0, 44'h0);
    fill(44'h700, 16'd3, 20'd0, T_BY, 44'h777, 2'd1); step();
    lk(44'h700, 16'd3, 20'd0, T_BY, 1'b1, 44'h777, 2'd1, "R8 fill survives invalidate"); step();
    lk(44'h600, 16'd3, 20'd0, T_BY, 1'b0, 0, 0, "R8 invalidate applied"); step();

    // R9: lookup sees pre-update contents
    lk(44'h800, 16'd4, 20'd1, T_NE, 1'b0, 0, 0, "R9 same-cycle fill not visible");
    fill(44'h800, 16'd4, 20'd1, T_NE, 44'h888, 2'd3); step();
    lk(44'h800, 16'd4, 20'd1, T_NE, 1'b1, 44'h888, 2'd3, "R9 fill visible next"); step();
    lk(44'h700, 16'd3, 20'd0, T_BY, 1'b1, 44'h777, 2'd1, "R9 same-cycle invalidate not visible");
    inv(T_BY, 1'b0, 1'b0, 1'b0, 16'd0, 20'd0, 44'h0); step();
    lk(44'h700, 16'd3, 20'd0, T_BY, 1'b0, 0, 0, "R9 invalidate visible next"); step();

    repeat (3) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_err++;
      $display("FAIL R3: missing responses actual=%0d pending expected=0", exp_q.size());
    end
    summary();
    $finish;
  end

endmodule